// File: doc/BRIEF.md
# Companding PCM Codec Serial Port

This block is the digital side of a voice-band telephone codec. It sits on a time-division-multiplexed serial bus that carries one 8-bit companded sample per frame in each direction. A bit clock paces the bus. The bit clock is synchronous to the block's master clock and runs slower than it. The block samples the bit clock in the master clock domain and acts on its rising and falling edges.

On the transmit side, the block compresses a 14-bit two's-complement linear sample into an 8-bit code. A run-time select input picks either the A-law or the µ-law curve. The code is shifted out most significant bit first while the transmit slot is open. The data output is driven only during that slot. An active-low strobe marks the same window so that an external open-drain pad can signal the slot.

On the receive side, a separate frame sync arms an 8-bit shift register. The shift register is fed on falling bit-clock edges. Only a complete byte is expanded back into a linear sample. A power-down input closes both directions.

Top module: `pcm_codec_port`

## Requirements
- R1: A transmit slot opens on a bit-clock rising edge at which `fs_tx` is high, the slot is idle and power-down is low. The code's bit 7 is presented at that edge, and each later rising edge presents the next lower bit, down to bit 0.
- R2: `tx_oe` is high for exactly eight bit-clock periods of a slot. It drops at the ninth rising edge, and is low after reset and between slots.
- R3: `slot_strobe_n` is low exactly while `tx_oe` is high, and high otherwise.
- R4: With `law_a_sel` low, µ-law coding is used. Take the magnitude of the sample, clip it to 8159 and add 33. The segment is the smallest s in 0..7 with biased < 64<<s. The mantissa is (biased>>(s+1)) & 15. The code is {0,s,mantissa} inverted, except that negative samples keep bit 7 low. A biased value of 8192 gives 0x80 for a positive sample and 0x00 for a negative one. A zero sample gives 0xFF.
- R5: With `law_a_sel` high, A-law coding is used on the 13-bit value x = sample>>>1. The magnitude is x if x≥0, otherwise -x-1. The segment is the smallest s with mag < 32<<s. The mantissa is (mag>>1)&15 for s<2 and (mag>>s)&15 otherwise. The code is {sign,s,mantissa} XOR 0x55, where the sign is 1 for x≥0. Zero gives 0xD5, 8191 gives 0xAA and -8192 gives 0x2A.
- R6: A bit-clock rising edge with `fs_rx` high arms the receiver, and also restarts a receiver that is already armed. The next eight falling edges sample `rx_data` MSB first.
- R7: `rx_sample` changes only after the eighth received bit. A slot cut short leaves it unchanged.
- R8: µ-law expansion: invert the code, then take s=bits[6:4] and m=bits[3:0]. The value is ((2m+33)<<s)-33, and it is negative when the inverted bit 7 is 1. 0xFF gives 0 and 0x80 gives 8031.
- R9: A-law expansion: XOR the code with 0x55, then take s and m. The 13-bit value is 2m+1 for s=0, otherwise (2m+33)<<(s-1). It is positive when bit 7 is 1. The output is that value times 2. 0xD5 gives 2, 0xAA gives 8064 and 0x2A gives -8064.
- R10: While `pwr_down` is high, `tx_oe` is low, `slot_strobe_n` is high and `rx_sample` is 0. A slot that was open is abandoned and does not resume.
- R11: After reset, `tx_oe` is low, `slot_strobe_n` is high and `rx_sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk | input | 1 | Bus bit clock, synchronous and slower than clk |
| law_a_sel | input | 1 | 1 selects A-law, 0 selects µ-law |
| pwr_down | input | 1 | 1 powers the port down |
| fs_tx | input | 1 | Transmit frame sync |
| tx_sample | input | 14 | Linear sample to encode (two's complement) |
| tx_data | output | 1 | Serial transmit bit, valid when tx_oe is high |
| tx_oe | output | 1 | Output enable of the tri-state transmit pad |
| slot_strobe_n | output | 1 | Active-low slot strobe for an open-drain pad |
| fs_rx | input | 1 | Receive frame sync |
| rx_data | input | 1 | Serial receive bit |
| rx_sample | output | 14 | Expanded linear sample (two's complement) |

## Verification
A wrong segment or mantissa in either encoder shows up on `tx_data` at the rising edge where the faulty bit is shifted out. That is within eight bit-clock periods of the frame sync. A transmit bit counter that is off by one widens or shortens the `tx_oe` window, which is visible at the ninth rising edge. A receive counter or holding register in the wrong state lets `rx_sample` move early after a cut-short slot, or leaves it holding the wrong value. Either fault is visible one master clock after the eighth falling edge. A power-down that fails to clear state is visible at the next bit-clock edge as a re-driven pad.

// File: rtl/pcm_law_pkg.sv
package pcm_law_pkg;
  localparam int LIN_W  = 14;
  localparam int CODE_W = 8;
  localparam int SEG_N  = 8;

  // u-law compression of a 14-bit sample
  function automatic logic [CODE_W-1:0] mulaw_encode(input logic [LIN_W-1:0] s);
    logic [LIN_W:0]    mag;
    logic [CODE_W-1:0] mask;
    logic [2:0]        seg;
    logic              over;
    logic [3:0]        mant;
    mag  = s[LIN_W-1] ? ((~{s[LIN_W-1], s}) + 15'd1) : {1'b0, s};
    mask = s[LIN_W-1] ? 8'h7F : 8'hFF;
    if (mag > 15'd8159) mag = 15'd8159;
    mag  = mag + 15'd33;
    over = 1'b1;
    seg  = 3'd0;
    for (int i = SEG_N - 1; i >= 0; i--) begin
      if (mag < (15'd64 << i)) begin
        seg  = 3'(i);
        over = 1'b0;
      end
    end
    mant = 4'(mag >> ({1'b0, seg} + 4'd1));
    return over ? (8'h7F ^ mask) : ({1'b0, seg, mant} ^ mask);
  endfunction

  // A-law compression of the upper 13 bits of a 14-bit sample
  function automatic logic [CODE_W-1:0] alaw_encode(input logic [LIN_W-1:0] s);
    logic [LIN_W-2:0]  x;
    logic [LIN_W-2:0]  mag;
    logic [CODE_W-1:0] mask;
    logic [2:0]        seg;
    logic [3:0]        mant;
    x    = s[LIN_W-1:1];
    mag  = x[LIN_W-2] ? ~x : x;
    mask = x[LIN_W-2] ? 8'h55 : 8'hD5;
    seg  = 3'd7;
    for (int i = SEG_N - 1; i >= 0; i--) begin
      if (mag < (13'd32 << i)) seg = 3'(i);
    end
    if (seg < 3'd2) mant = 4'(mag >> 1);
    else            mant = 4'(mag >> seg);
    return {1'b0, seg, mant} ^ mask;
  endfunction

  function automatic logic [LIN_W-1:0] mulaw_decode(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] u;
    logic [LIN_W:0]    t;
    logic [LIN_W-1:0]  r;
    u = ~c;
    t = ((15'(u[3:0]) << 1) + 15'd33) << u[6:4];
    t = t - 15'd33;
    r = t[LIN_W-1:0];
    return u[7] ? (~r + 14'd1) : r;
  endfunction

  function automatic logic [LIN_W-1:0] alaw_decode(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] a;
    logic [LIN_W-1:0]  t;
    a = c ^ 8'h55;
    if (a[6:4] == 3'd0) t = (14'(a[3:0]) << 1) + 14'd1;
    else                t = ((14'(a[3:0]) << 1) + 14'd33) << (a[6:4] - 3'd1);
    t = t << 1;
    return a[7] ? t : (~t + 14'd1);
  endfunction
endpackage

// File: rtl/pcm_bclk_edges.sv
module pcm_bclk_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  output logic bit_rise,
  output logic bit_fall
);
  logic bclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_q <= 1'b0;
    else        bclk_q <= bclk;
  end

  assign bit_rise = bclk & ~bclk_q;
  assign bit_fall = ~bclk & bclk_q;

  // R1 edges are single-cycle events
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise |=> !bit_rise);
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
  import pcm_law_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rise,
  input  logic             fs,
  input  logic             pd,
  input  logic             law_a,
  input  logic [LIN_W-1:0] sample,
  output logic             data,
  output logic             oe,
  output logic             strobe_n
);
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic              active;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] shreg;
  logic [CODE_W-1:0] code;
  logic              slot_start;
  logic              slot_last;

  assign code       = law_a ? alaw_encode(sample) : mulaw_encode(sample);
  assign slot_start = bit_rise & fs & ~active & ~pd;
  assign slot_last  = bit_rise & active & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
    end else if (pd) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (slot_start) begin
      active <= 1'b1;
      cnt    <= '0;
      shreg  <= code;
    end else if (bit_rise && active) begin
      if (cnt == LAST) begin
        active <= 1'b0;
      end else begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[CODE_W-2:0], 1'b0};
      end
    end
  end

  assign data     = shreg[CODE_W-1];
  assign oe       = active & ~pd;
  assign strobe_n = ~oe;

  // R1
  slot_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> (oe || pd));
  // R2
  slot_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_last |=> !oe);
  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !bit_rise && !pd) |=> $stable(data));
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
  import pcm_law_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_rise,
  input  logic             bit_fall,
  input  logic             fs,
  input  logic             pd,
  input  logic             law_a,
  input  logic             din,
  output logic [LIN_W-1:0] sample
);
  localparam int CNT_W = $clog2(CODE_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CODE_W - 1);

  logic              armed;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-2:0] shreg;
  logic [CODE_W-1:0] byte_in;
  logic              arm;
  logic              take;
  logic              byte_done;

  assign arm       = bit_rise & fs & ~pd;
  assign take      = bit_fall & armed & ~pd;
  assign byte_done = take & (cnt == LAST);
  assign byte_in   = {shreg, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      cnt    <= '0;
      shreg  <= '0;
      sample <= '0;
    end else if (pd) begin
      armed  <= 1'b0;
      cnt    <= '0;
      sample <= '0;
    end else begin
      if (arm) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (take) begin
        shreg <= byte_in[CODE_W-2:0];
        if (cnt == LAST) armed <= 1'b0;
        else             cnt   <= cnt + 1'b1;
      end
      if (byte_done)
        sample <= law_a ? alaw_decode(byte_in) : mulaw_decode(byte_in);
    end
  end

  // R7
  hold_until_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_done && !pd) |=> $stable(sample));
  // R10
  pd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (sample == '0));
  // R6
  disarm_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> !armed);
endmodule

// File: rtl/pcm_codec_port.sv
module pcm_codec_port
  import pcm_law_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bclk,
  input  logic             law_a_sel,
  input  logic             pwr_down,
  input  logic             fs_tx,
  input  logic [LIN_W-1:0] tx_sample,
  output logic             tx_data,
  output logic             tx_oe,
  output logic             slot_strobe_n,
  input  logic             fs_rx,
  input  logic             rx_data,
  output logic [LIN_W-1:0] rx_sample
);
  logic bit_rise;
  logic bit_fall;

  pcm_bclk_edges u_edges (
    .clk(clk), .rst_n(rst_n), .bclk(bclk),
    .bit_rise(bit_rise), .bit_fall(bit_fall)
  );

  pcm_tx_slot u_tx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .fs(fs_tx),
    .pd(pwr_down), .law_a(law_a_sel), .sample(tx_sample),
    .data(tx_data), .oe(tx_oe), .strobe_n(slot_strobe_n)
  );

  pcm_rx_slot u_rx (
    .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .bit_fall(bit_fall),
    .fs(fs_rx), .pd(pwr_down), .law_a(law_a_sel), .din(rx_data),
    .sample(rx_sample)
  );

  // R10
  pd_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_down) |-> (!tx_oe && slot_strobe_n));
endmodule

// File: tb/pcm_codec_port_tb.sv
module pcm_codec_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0;
  logic law_a_sel = 1'b0;
  logic pwr_down = 1'b0;
  logic fs_tx = 1'b0;
  logic fs_rx = 1'b0;
  logic rx_data = 1'b0;
  logic [13:0] tx_sample = '0;
  logic tx_data, tx_oe, slot_strobe_n;
  logic [13:0] rx_sample;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pcm_codec_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk(bclk), .law_a_sel(law_a_sel),
    .pwr_down(pwr_down), .fs_tx(fs_tx), .tx_sample(tx_sample),
    .tx_data(tx_data), .tx_oe(tx_oe), .slot_strobe_n(slot_strobe_n),
    .fs_rx(fs_rx), .rx_data(rx_data), .rx_sample(rx_sample)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // reference models, formulated by repeated halving
  function automatic int ref_mu_enc(input int s);
    int m, e, neg, code;
    neg = (s < 0);
    m = neg ? -s : s;
    if (m > 8159) m = 8159;
    m = m + 33;
    e = 0;
    while (e < 8 && (m >> (e + 6)) != 0) e++;
    if (e == 8) code = 127;
    else code = e * 16 + ((m >> (e + 1)) % 16);
    code = 255 - code;
    if (neg) code = code - 128;
    return code;
  endfunction

  function automatic int ref_a_enc(input int s);
    int x, m, e, code;
    x = s >>> 1;
    m = (x < 0) ? (-x - 1) : x;
    e = 0;
    while (e < 7 && (m >> (e + 5)) != 0) e++;
    code = e * 16 + (((e < 2) ? (m >> 1) : (m >> e)) % 16);
    if (x >= 0) code = code + 128;
    return code ^ 8'h55;
  endfunction

  function automatic int ref_mu_dec(input int c);
    int u, v;
    u = 255 - c;
    v = (2 * (u % 16) + 33) * (1 << ((u / 16) % 8)) - 33;
    return (u >= 128) ? -v : v;
  endfunction

  function automatic int ref_a_dec(input int c);
    int a, e, v;
    a = c ^ 8'h55;
    e = (a / 16) % 8;
    v = (e == 0) ? (2 * (a % 16) + 1) : (2 * (a % 16) + 33) * (1 << (e - 1));
    v = v * 2;
    return (a >= 128) ? v : -v;
  endfunction

  function automatic int as_int(input logic [13:0] v);
    return int'($signed(v));
  endfunction

  task automatic half_low();
    @(negedge clk) bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  // one complete frame: transmit tx value, receive rx code
  task automatic frame(input int txv, input int rxc, input bit law);
    int exp_code, exp_rx;
    law_a_sel = law;
    tx_sample = 14'(txv);
    exp_code  = law ? ref_a_enc(txv) : ref_mu_enc(txv);
    exp_rx    = law ? ref_a_dec(rxc) : ref_mu_dec(rxc);
    fs_tx = 1'b1;
    fs_rx = 1'b1;
    rx_data = rxc[7];
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) bclk = 1'b1;
      repeat (3) @(negedge clk);
      // R1 R4 R5 serial bits, MSB first
      check(tx_data == exp_code[i], law ? "R1/R5 tx bit" : "R1/R4 tx bit",
            int'(tx_data), exp_code[i]);
      // R2 R3 window open
      check(tx_oe && !slot_strobe_n, "R2/R3 slot open", int'(tx_oe), 1);
      fs_tx = 1'b0;
      fs_rx = 1'b0;
      half_low();
      if (i > 0) rx_data = rxc[i-1];
    end
    @(negedge clk) bclk = 1'b1;
    repeat (3) @(negedge clk);
    check(!tx_oe && slot_strobe_n, "R2/R3 slot closed after 8 bits", int'(tx_oe), 0);
    // R6 R8 R9 expanded sample
    check(as_int(rx_sample) == exp_rx, law ? "R6/R9 rx sample" : "R6/R8 rx sample",
          as_int(rx_sample), exp_rx);
    half_low();
  endtask

  localparam int NV = 12;
  localparam int VEC_TX  [NV] = '{0, 1, -1, 100, -100, 2047, -3000, 8191, -8192, 5000, 31, -33};
  localparam int VEC_RX  [NV] = '{8'hFF, 8'h80, 8'h00, 8'hD5, 8'hAA, 8'h2A, 8'h7F, 8'h55, 8'h3C, 8'hE1, 8'h91, 8'h0F};
  localparam bit VEC_LAW [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check(!tx_oe && slot_strobe_n && rx_sample == '0, "R11 reset outputs",
          int'(tx_oe), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!tx_oe && slot_strobe_n, "R11 idle after reset", int'(slot_strobe_n), 1);

    // fixed anchor points, independent of the models
    check(ref_mu_enc(0) == 8'hFF && ref_mu_enc(8191) == 8'h80, "R4 anchors", ref_mu_enc(0), 255);
    check(ref_a_enc(0) == 8'hD5 && ref_a_enc(-8192) == 8'h2A, "R5 anchors", ref_a_enc(0), 213);

    for (int v = 0; v < NV; v++) frame(VEC_TX[v], VEC_RX[v], VEC_LAW[v]);

    // R7 partial slot leaves sample unchanged, new sync restarts
    frame(0, 8'h80, 1'b0);
    check(as_int(rx_sample) == 8031, "R8 0x80 to 8031", as_int(rx_sample), 8031);
    fs_rx = 1'b1;
    rx_data = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk) bclk = 1'b1;
      repeat (3) @(negedge clk);
      fs_rx = 1'b0;
      half_low();
    end
    check(as_int(rx_sample) == 8031, "R7 partial slot ignored", as_int(rx_sample), 8031);
    frame(0, 8'hAA, 1'b1);
    check(as_int(rx_sample) == 8064, "R7/R9 restart after partial", as_int(rx_sample), 8064);

    // R10 power-down mid slot
    tx_sample = 14'd0;
    fs_tx = 1'b1;
    fs_rx = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk) bclk = 1'b1;
      repeat (3) @(negedge clk);
      fs_tx = 1'b0;
      fs_rx = 1'b0;
      half_low();
    end
    check(tx_oe == 1'b1, "R1 slot open before power-down", int'(tx_oe), 1);
    @(negedge clk) pwr_down = 1'b1;
    repeat (2) @(negedge clk);
    check(!tx_oe && slot_strobe_n && rx_sample == '0, "R10 powered down",
          as_int(rx_sample), 0);
    @(negedge clk) bclk = 1'b1;
    repeat (3) @(negedge clk);
    check(!tx_oe, "R10 ignores sync edge while down", int'(tx_oe), 0);
    half_low();
    @(negedge clk) pwr_down = 1'b0;
    @(negedge clk) bclk = 1'b1;
    repeat (3) @(negedge clk);
    check(!tx_oe && slot_strobe_n, "R10 aborted slot stays closed", int'(tx_oe), 0);
    half_low();
    frame(-1, 8'hD5, 1'b1);
    check(as_int(rx_sample) == 2, "R9 0xD5 to 2", as_int(rx_sample), 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule